// File: doc/BRIEF.md
# Halfband 2x Chroma Interpolator

This block raises the sample rate of signed chroma channels by two, turning 4:2:2 colour-difference data into 4:4:4. For each channel it keeps a short history of input samples. On alternate clock edges it emits either an original sample unchanged or a new sample halfway between two originals. The new sample comes from a 7-tap halfband filter with taps (-1, 0, 9, 16, 9, 0, -1)/16. Every filter result goes through a round/select/limit stage before it reaches the output register. The stage adds half an output LSB, shifts right by the fraction width, and clamps to plus or minus 448.

A single-cycle `init` pulse starts the interpolator. It comes from the upstream sync falling edge that marks the first chroma sample. The pulse clears the history of every channel, takes the sample present on that edge as the first sample, and fixes the phase. From then on, all channels run in lock step under one `out_valid`.

Luma is not filtered. It runs through a delay line whose length is set at run time by `luma_dly`. The delay is always two edges longer than the programmed value. Chroma has a latency of 5 edges, so programming 3 keeps luma aligned with the interpolated chroma.

Top module: `hb_chroma_interp`

## Requirements
- R1: After reset and before the first `init`, `out_valid` is 0 and every `chroma_out` lane is 0, whatever the inputs do.
- R2: On an edge where `init` is 1:
  - every channel's history is cleared and the sample on `chroma_in` is taken as sample x0;
  - after that edge `chroma_out` is 0 and `out_valid` is 1;
  - later outputs treat every sample before x0 as zero, even if earlier data was loaded.
- R3: Counting the `init` edge as edge 0, `chroma_in` is sampled only on even edges (sample xk on edge 2k). Values on odd edges have no effect on the output.
- R4: After edge 2k+1 each channel outputs x(k-2), limited as in R6. This is the pass-through phase.
- R5: After edge 2k+2 each channel outputs (-x(k-3) + 9x(k-2) + 9x(k-1) - x(k) + 8) shifted arithmetically right by 4 (floor), limited as in R6. This is the interpolated phase.
- R6: Every chroma output in both phases lies in [-448, +448]. Values outside this range are replaced by the nearer limit.
- R7: `luma_out` equals the `luma_in` value presented `luma_dly`+2 edges earlier, for any `luma_dly` from 0 to 63. `init` does not affect it.
- R8: One `out_valid` serves all channels. Once set by `init` it stays 1 until reset. Lane 0 (Cb) and lane 1 (Cr) are filtered independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Start pulse: clears history, loads x0, sets phase |
| chroma_in | input | NCH*W (2x10) | Signed chroma samples, lane 0 Cb, lane 1 Cr |
| luma_in | input | W (10) | Unsigned luma sample, one per edge |
| luma_dly | input | DLY_W (6) | Programmed luma delay; total delay is this value plus 2 |
| out_valid | output | 1 | Chroma output stream active |
| chroma_out | output | NCH*W (2x10) | Signed interpolated chroma, one sample per edge |
| luma_out | output | W (10) | Delayed luma |

## Verification
The assertions expect `init` to be a clean synchronous pulse. They also expect `chroma_in` to carry a known value on every sampling edge. They assume nothing about the range of those values, so the limit check must hold even for full-scale inputs such as +511 and -512.

The phase-alternation assertion only applies while `init` is low. The stimulus therefore raises `init` for exactly one cycle per stream, both from a clean start and in the middle of a running stream. It drives deliberate non-zero values on the odd edges that the block must ignore.

`luma_dly` is changed only between scenarios. Luma is checked only once the delay line has refilled at the new setting.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

   // Phase of the next clock edge once the interpolator is running.
   typedef enum logic {
      PH_MID  = 1'b0,  // emit interpolated sample, load a new input sample
      PH_PASS = 1'b1   // emit an original sample, hold the history
   } hbi_phase_e;

   // Accumulator width: data width plus coefficient fraction plus headroom.
   function automatic int hbi_acc_width(input int w, input int frac);
      return w + frac + 2;
   endfunction

endpackage

// File: rtl/hbi_rsl.sv
module hbi_rsl #(
   parameter int ACC_W = 16,
   parameter int W     = 10,
   parameter int FRAC  = 4,
   parameter int LIMIT = 448
) (
   input  logic signed [ACC_W-1:0] acc,
   output logic signed [W-1:0]     res
);

   localparam logic signed [ACC_W:0] RND = (ACC_W+1)'(2 ** (FRAC - 1));
   localparam logic signed [ACC_W:0] HI  = (ACC_W+1)'(LIMIT);
   localparam logic signed [ACC_W:0] LO  = -HI;

   logic signed [ACC_W:0] rounded;
   logic signed [ACC_W:0] selected;

   always_comb begin
      rounded  = $signed({acc[ACC_W-1], acc}) + RND;
      selected = rounded >>> FRAC;
      if (selected > HI)
         res = HI[W-1:0];
      else if (selected < LO)
         res = LO[W-1:0];
      else
         res = selected[W-1:0];
   end

endmodule

// File: rtl/hbi_chan.sv
module hbi_chan #(
   parameter int W     = 10,
   parameter int FRAC  = 4,
   parameter int ACC_W = 16,
   parameter int C_IN  = 9,
   parameter int C_OUT = -1,
   parameter int LIMIT = 448
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic         emit,
   input  logic         sel_pass,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   localparam int NHIST = 4;
   localparam logic signed [ACC_W-1:0] KIN  = ACC_W'(C_IN);
   localparam logic signed [ACC_W-1:0] KOUT = ACC_W'(C_OUT);

   logic [NHIST-1:0][W-1:0]  hist;
   logic signed [ACC_W-1:0]  ex [NHIST];
   logic signed [ACC_W-1:0]  acc_pass, acc_mid, acc_sel;
   logic signed [W-1:0]      rsl_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hist <= '0;
      else if (clr)
         hist <= {{((NHIST-1)*W){1'b0}}, din};
      else if (load)
         hist <= {hist[NHIST-2:0], din};
   end

   for (genvar i = 0; i < NHIST; i++) begin : g_ext
      assign ex[i] = ACC_W'($signed(hist[i]));
   end

   // hist[0] newest; the midpoint falls between hist[2] and hist[1]
   assign acc_pass = ex[2] <<< FRAC;
   assign acc_mid  = KIN * (ex[1] + ex[2]) + KOUT * (ex[0] + ex[3]);
   assign acc_sel  = sel_pass ? acc_pass : acc_mid;

   hbi_rsl #(
      .ACC_W (ACC_W),
      .W     (W),
      .FRAC  (FRAC),
      .LIMIT (LIMIT)
   ) u_rsl (
      .acc (acc_sel),
      .res (rsl_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dout <= '0;
      else if (clr)
         dout <= '0;
      else if (emit)
         dout <= rsl_res;
   end

   // R6: output never leaves the limit window
   a_r6_in_limit: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(dout) <= LIMIT) && ($signed(dout) >= -LIMIT));

   // R2: a clear leaves the output at zero on the next cycle
   a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (dout == '0));

endmodule

// File: rtl/hbi_ydly.sv
module hbi_ydly #(
   parameter int W     = 10,
   parameter int DLY_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     din,
   input  logic [DLY_W-1:0] dly,
   output logic [W-1:0]     dout
);

   localparam int DEPTH = 1 << DLY_W;

   logic [W-1:0]            din_q;
   logic [DEPTH-1:0][W-1:0] line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         din_q <= '0;
         line  <= '0;
         dout  <= '0;
      end else begin
         din_q <= din;
         line  <= {line[DEPTH-2:0], din_q};
         dout  <= line[dly];
      end
   end

endmodule

// File: rtl/hb_chroma_interp.sv
module hb_chroma_interp
   import hbi_pkg::*;
#(
   parameter int W     = 10,
   parameter int NCH   = 2,
   parameter int FRAC  = 4,
   parameter int C_IN  = 9,
   parameter int C_OUT = -1,
   parameter int LIMIT = 448,
   parameter int DLY_W = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    init,
   input  logic [NCH-1:0][W-1:0]   chroma_in,
   input  logic [W-1:0]            luma_in,
   input  logic [DLY_W-1:0]        luma_dly,
   output logic                    out_valid,
   output logic [NCH-1:0][W-1:0]   chroma_out,
   output logic [W-1:0]            luma_out
);

   localparam int ACC_W = hbi_acc_width(W, FRAC);

   // elaboration-time parameter checks
   if (W < 4) begin : g_bad_width
      $error("hb_chroma_interp: W must be at least 4");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("hb_chroma_interp: NCH must be at least 1");
   end
   if (FRAC < 1) begin : g_bad_frac
      $error("hb_chroma_interp: FRAC must be at least 1");
   end
   if (2 * C_IN + 2 * C_OUT != 2 ** FRAC) begin : g_bad_coef
      $error("hb_chroma_interp: odd taps must sum to unity gain");
   end
   if (LIMIT < 1 || LIMIT >= 2 ** (W - 1)) begin : g_bad_limit
      $error("hb_chroma_interp: LIMIT must fit a signed W-bit word");
   end

   logic       active;
   hbi_phase_e ph;
   logic       load, emit, sel_pass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         ph        <= PH_MID;
         out_valid <= 1'b0;
      end else if (init) begin
         active    <= 1'b1;
         ph        <= PH_PASS;
         out_valid <= 1'b1;
      end else if (active) begin
         ph <= (ph == PH_MID) ? PH_PASS : PH_MID;
      end
   end

   assign load     = init | (active & (ph == PH_MID));
   assign emit     = active & ~init;
   assign sel_pass = (ph == PH_PASS);

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      hbi_chan #(
         .W     (W),
         .FRAC  (FRAC),
         .ACC_W (ACC_W),
         .C_IN  (C_IN),
         .C_OUT (C_OUT),
         .LIMIT (LIMIT)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (init),
         .load     (load),
         .emit     (emit),
         .sel_pass (sel_pass),
         .din      (chroma_in[c]),
         .dout     (chroma_out[c])
      );
   end

   hbi_ydly #(
      .W     (W),
      .DLY_W (DLY_W)
   ) u_ydly (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (luma_in),
      .dly   (luma_dly),
      .dout  (luma_out)
   );

   // R1: nothing leaves the chroma outputs until the stream starts
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (chroma_out == '0));

   // R2: init starts the stream on the pass-through phase
   a_r2_init_start: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (out_valid && ph == PH_PASS));

   // R3: sampling and emitting phases alternate edge by edge
   a_r3_phase_alt: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !init) |=> (ph != $past(ph)));

   // R8: the shared valid holds once raised
   a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> out_valid);

endmodule

// File: tb/hb_chroma_interp_test.sv
`timescale 1ns/1ps
module hb_chroma_interp_test;

   localparam int W     = 10;
   localparam int NCH   = 2;
   localparam int DLY_W = 6;
   localparam int LIM   = 448;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  init = 1'b0;
   logic [NCH-1:0][W-1:0] chroma_in = '0;
   logic [W-1:0]          luma_in = '0;
   logic [DLY_W-1:0]      luma_dly = 6'd3;
   logic                  out_valid;
   logic [NCH-1:0][W-1:0] chroma_out;
   logic [W-1:0]          luma_out;

   hb_chroma_interp uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .init       (init),
      .chroma_in  (chroma_in),
      .luma_in    (luma_in),
      .luma_dly   (luma_dly),
      .out_valid  (out_valid),
      .chroma_out (chroma_out),
      .luma_out   (luma_out)
   );

   always #10 clk = ~clk;  // 50 MHz

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   int xs [NCH][16];
   int n_smp = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int xv(input int c, input int k);
      if (k < 0 || k >= n_smp) return 0;
      return xs[c][k];
   endfunction

   function automatic int clampv(input int v);
      if (v > LIM) return LIM;
      if (v < -LIM) return -LIM;
      return v;
   endfunction

   function automatic int rslv(input int acc);
      return clampv((acc + 8) >>> 4);
   endfunction

   function automatic int expect_out(input int c, input int e);
      int k;
      if (e == 0) return 0;
      if (e % 2 == 1) begin
         k = (e - 1) / 2;
         return rslv(16 * xv(c, k - 2));
      end
      k = (e - 2) / 2;
      return rslv(-xv(c, k - 3) + 9 * xv(c, k - 2) + 9 * xv(c, k - 1) - xv(c, k));
   endfunction

   // Starts a stream with init, drives xs on even edges and junk on odd ones
   task automatic run_stream(input string tag, input int junk);
      for (int e = 0; e < 2 * n_smp + 6; e++) begin
         init = (e == 0);
         for (int c = 0; c < NCH; c++)
            chroma_in[c] = (e % 2 == 0) ? W'(xv(c, e / 2)) : W'(junk + 3 * c);
         @(posedge clk);
         @(negedge clk);
         init = 1'b0;
         chk($sformatf("%s R8 valid e%0d", tag, e), int'(out_valid), 1);
         for (int c = 0; c < NCH; c++) begin
            string req;
            req = (e == 0) ? "R2" : ((e % 2 == 1) ? "R4" : "R5");
            chk($sformatf("%s %s ch%0d e%0d", tag, req, c, e),
                int'($signed(chroma_out[c])), expect_out(c, e));
         end
      end
   endtask

   task automatic clear_xs();
      for (int c = 0; c < NCH; c++)
         for (int k = 0; k < 16; k++)
            xs[c][k] = 0;
   endtask

   // R1: reset state and idle before init
   task automatic t_reset();
      rst_n = 1'b0;
      chroma_in = {10'sd200, -10'sd150};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         chroma_in[0] = W'(37 * i + 5);
         chroma_in[1] = W'(-60 * i);
         @(negedge clk);
         chk("R1 valid idle", int'(out_valid), 0);
         chk("R1 lane0 idle", int'($signed(chroma_out[0])), 0);
         chk("R1 lane1 idle", int'($signed(chroma_out[1])), 0);
      end
   endtask

   task automatic t_impulse();
      clear_xs();
      n_smp = 6;
      xs[0][0] = 100;
      xs[1][1] = -37;
      run_stream("impulse", 0);
   endtask

   // R3: odd-edge data must be ignored
   task automatic t_ramp();
      clear_xs();
      n_smp = 10;
      for (int k = 0; k < 10; k++) begin
         xs[0][k] = 40 * k - 200;
         xs[1][k] = 300 - 55 * k;
      end
      run_stream("R3 ramp", 511);
   endtask

   // R6: overshoot and out-of-range inputs clamp to +-448
   task automatic t_clamp();
      clear_xs();
      n_smp = 8;
      xs[0][0] = -448; xs[0][1] = 448; xs[0][2] = 448; xs[0][3] = -448;
      xs[0][4] = 511;  xs[0][5] = 511; xs[0][6] = -512; xs[0][7] = -512;
      xs[1][0] = 448;  xs[1][1] = -448; xs[1][2] = -448; xs[1][3] = 448;
      run_stream("R6 clamp", 170);
   endtask

   // R2: a second init mid-stream discards the loaded history
   task automatic t_restart();
      init = 1'b1;
      chroma_in = {10'sd300, 10'sd300};
      @(negedge clk);
      init = 1'b0;
      repeat (5) @(negedge clk);
      clear_xs();
      n_smp = 4;
      xs[0][0] = 64; xs[0][1] = -128;
      xs[1][0] = -96; xs[1][2] = 250;
      run_stream("R2 restart", 77);
   endtask

   // R7: luma delay equals the programmed value plus two
   task automatic t_luma(input int dl);
      int hist [80];
      luma_dly = DLY_W'(dl);
      for (int t = 0; t < dl + 12; t++) begin
         hist[t] = (t * 53 + dl * 7 + 11) % 1024;
         luma_in = W'(hist[t]);
         if (t == 4) init = 1'b1;
         @(posedge clk);
         @(negedge clk);
         init = 1'b0;
         if (t >= dl + 2)
            chk($sformatf("R7 luma dly%0d t%0d", dl, t), int'(luma_out), hist[t - dl - 2]);
      end
   endtask

   initial begin
      t_reset();
      t_impulse();
      t_ramp();
      t_clamp();
      t_restart();
      t_luma(0);
      t_luma(3);
      t_luma(63);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule